// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects an on-chip valid/ready request port to an external asynchronous static RAM of 524,288 bytes. Each request is a single read or a single write. The controller produces the active-low chip-select, read-strobe and write-strobe waveforms, presents the 19-bit address, and drives the 8-bit data bus through a separate output value and output-enable pair. It takes the returned byte from a dedicated input. Read data comes back on a one-cycle valid pulse. Between requests the chip is deselected so that it draws standby current.

Every memory timing interval is a whole number of clock cycles, set by a parameter. By default each parameter is the nanosecond minimum of a 10 ns speed grade divided by the clock period and rounded up. The strobe width, the data setup and the bus turnaround are each timed on their own. The controller never turns on its data drivers while the memory may still be driving the bus. All pin outputs come straight from flops.

Pin encoding: select low with strobe low and write high is a read. Select low with write low is a write, whatever the read strobe is. Select low with both strobes high leaves the bus released. Select high deselects the chip.

Top module: `async_sram_ctrl`

## Requirements
- R1: During reset and whenever no request is in progress, `req_ready_o` is 1, `mem_cs_no`, `mem_oe_no` and `mem_we_no` are all 1 (deasserted), `mem_dq_oe_o` is 0 and `rd_valid_o` is 0.
- R2: An accepted read (`req_we_i`=0) drives `mem_cs_no`=0, `mem_oe_no`=0, `mem_we_no`=1 and `mem_dq_oe_o`=0, with `mem_addr_o` equal to the request address, from the cycle after acceptance for RD_LEN = max(T_AA, T_RC) cycles.
- R3: `mem_dq_i` is sampled at the last edge of that window. `rd_valid_o` is 1 for exactly one cycle, the (RD_LEN+1)-th cycle after the accepting edge, with the sampled byte on `rd_data_o`.
- R4: An accepted write (`req_we_i`=1) holds `mem_cs_no`=0 and `mem_oe_no`=1 throughout. `mem_we_no` stays 1 for SETUP_LEN cycles, where SETUP_LEN = T_DW−T_WP if T_DW>T_WP and 1 otherwise. It is then 0 for exactly T_WP cycles, and 1 again for END_LEN = max(1, T_RC−SETUP_LEN−T_WP) cycles before deselect.
- R5: The write byte is on `mem_dq_o` with `mem_dq_oe_o`=1 for at least T_DW cycles before `mem_we_no` rises, and it stays driven and unchanged in the cycle after the rise.
- R6: `mem_dq_oe_o` is never 1 while `mem_oe_no` is 0 or `mem_cs_no` is 1. At least T_TURN cycles pass between `mem_oe_no` rising and `mem_dq_oe_o` rising.
- R7: `req_ready_o` is 0 from the cycle after acceptance until the request completes. A write keeps the controller busy for SETUP_LEN+T_WP+END_LEN cycles and a read for RD_LEN+1+T_TURN cycles.
- R8: `mem_addr_o` does not change while `mem_cs_no` stays 0.
- R9: A read returns the byte last written to the same address, for any of the 2^19 addresses and any byte value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle; the request is taken on this edge |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | One-cycle read-data strobe |
| rd_data_o | output | 8 | Read byte |
| mem_addr_o | output | 19 | Memory address pins |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Read strobe, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | 8 | Data bus input value |

## Verification
The properties assume three things. The clock period used to derive the cycle counts is the real one. The memory stops driving within T_TURN cycles of its read strobe rising. Requests arrive only through the valid/ready handshake, so the address and data registers change only when the controller is idle. The bench drives every request at the falling edge and holds `req_valid_i` for a single accepted cycle. Its memory model returns the stored byte only after T_AA cycles of a stable read selection and treats the bus as driven for T_TURN cycles after the strobe rises, so early sampling or driver overlap is visible at the ports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END,
    ST_TURN
  } sram_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= cap_en_i;
      if (cap_en_i) data_q <= dq_i;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  // one capture per read, so the strobe never lasts two cycles
  AST_RD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R3

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 2,
  parameter int RD_LEN    = 2,
  parameter int SETUP_LEN = 1,
  parameter int T_WP      = 2,
  parameter int END_LEN   = 1,
  parameter int T_TURN    = 1,
  parameter int T_DW      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              cap_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  localparam int AW_CNT = CNT_W + 1;

  sram_state_e       state_q, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dq_q;
  logic              cs_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic              accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    nxt        = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cap_en_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        tmr_load_o = 1'b1;
        if (req_we_i) begin
          nxt       = ST_WR_SETUP;
          tmr_val_o = CNT_W'(SETUP_LEN - 1);
        end else begin
          nxt       = ST_RD_WAIT;
          tmr_val_o = CNT_W'(RD_LEN - 1);
        end
      end
      ST_RD_WAIT: if (tmr_done_i) begin
        nxt      = ST_RD_CAPTURE;
        cap_en_o = 1'b1;
      end
      ST_RD_CAPTURE: begin
        nxt        = ST_TURN;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(T_TURN - 1);
      end
      ST_WR_SETUP: if (tmr_done_i) begin
        nxt        = ST_WR_PULSE;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(T_WP - 1);
      end
      ST_WR_PULSE: if (tmr_done_i) begin
        nxt        = ST_WR_END;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(END_LEN - 1);
      end
      ST_WR_END: if (tmr_done_i) nxt = ST_IDLE;
      ST_TURN:   if (tmr_done_i) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // pins are decoded from the next state and registered, so they never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      addr_q  <= '0;
      dq_q    <= '0;
    end else begin
      state_q <= nxt;
      cs_n_q  <= (nxt == ST_IDLE) || (nxt == ST_RD_CAPTURE) || (nxt == ST_TURN);
      oe_n_q  <= (nxt != ST_RD_WAIT);
      we_n_q  <= (nxt != ST_WR_PULSE);
      dq_oe_q <= (nxt == ST_WR_SETUP) || (nxt == ST_WR_PULSE) || (nxt == ST_WR_END);
      if (accept) begin
        addr_q <= req_addr_i;
        if (req_we_i) dq_q <= req_wdata_i;
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_cs_no   = cs_n_q;
  assign mem_oe_no   = oe_n_q;
  assign mem_we_no   = we_n_q;
  assign mem_dq_o    = dq_q;
  assign mem_dq_oe_o = dq_oe_q;

  // assertion support: saturating interval counters
  logic [AW_CNT-1:0] we_lo_cnt, dq_on_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      dq_on_cnt <= '0;
      oe_hi_cnt <= '1;
    end else begin
      if (we_n_q)                 we_lo_cnt <= '0;
      else if (we_lo_cnt != '1)   we_lo_cnt <= we_lo_cnt + 1'b1;
      if (!dq_oe_q)               dq_on_cnt <= '0;
      else if (dq_on_cnt != '1)   dq_on_cnt <= dq_on_cnt + 1'b1;
      if (!oe_n_q)                oe_hi_cnt <= '0;
      else if (oe_hi_cnt != '1)   oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_n_q && oe_n_q && we_n_q && !dq_oe_q); // R1

  AST_RD_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> !cs_n_q && we_n_q && !dq_oe_q); // R2

  AST_WE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> !cs_n_q && oe_n_q && dq_oe_q); // R4

  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> int'(we_lo_cnt) == T_WP); // R4

  AST_DATA_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> dq_oe_q && int'(dq_on_cnt) >= T_DW); // R5

  AST_DATA_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_q && $past(dq_oe_q)) |-> $stable(dq_q)); // R5

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_q |-> oe_n_q && !cs_n_q); // R6

  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_q) |-> int'(oe_hi_cnt) >= T_TURN); // R6

  AST_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_q && $past(!cs_n_q)) |-> $stable(addr_q)); // R8

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_RC          = ceil_div(10000, CLK_PERIOD_PS),
  parameter int T_WP          = ceil_div(7000, CLK_PERIOD_PS),
  parameter int T_DW          = ceil_div(5000, CLK_PERIOD_PS),
  parameter int T_AA          = ceil_div(10000, CLK_PERIOD_PS),
  parameter int T_TURN        = ceil_div(5000, CLK_PERIOD_PS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_LEN    = max2(T_AA, T_RC);
  localparam int SETUP_LEN = (T_DW > T_WP) ? (T_DW - T_WP) : 1;
  localparam int END_LEN   = max2(1, T_RC - SETUP_LEN - T_WP);
  localparam int MAX_LEN   = max2(max2(RD_LEN, SETUP_LEN), max2(max2(T_WP, END_LEN), T_TURN));
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  if (T_RC < 1 || T_WP < 1 || T_DW < 1 || T_AA < 1 || T_TURN < 1) begin : g_bad_timing
    $error("async_sram_ctrl: every timing interval must be at least one cycle");
  end

  logic             tmr_load, tmr_done, cap_en;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .RD_LEN    (RD_LEN),
    .SETUP_LEN (SETUP_LEN),
    .T_WP      (T_WP),
    .END_LEN   (END_LEN),
    .T_TURN    (T_TURN),
    .T_DW      (T_DW)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cap_en_o    (cap_en),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_no   (mem_cs_no),
    .mem_oe_no   (mem_oe_no),
    .mem_we_no   (mem_we_no),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en),
    .dq_i       (mem_dq_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: tb/test_async_sram_ctrl.sv
`timescale 1ns/1ps
module test_async_sram_ctrl;

  localparam int CLK_PS   = 5000;
  localparam int B_RC     = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int B_WP     = (7000 + CLK_PS - 1) / CLK_PS;
  localparam int B_DW     = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int B_AA     = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int B_TURN   = (5000 + CLK_PS - 1) / CLK_PS;
  localparam int B_RD_LEN = (B_AA > B_RC) ? B_AA : B_RC;
  localparam int B_SETUP  = (B_DW > B_WP) ? (B_DW - B_WP) : 1;
  localparam int B_END    = ((B_RC - B_SETUP - B_WP) > 1) ? (B_RC - B_SETUP - B_WP) : 1;
  localparam int WR_BUSY  = B_SETUP + B_WP + B_END;
  localparam int RD_BUSY  = B_RD_LEN + 1 + B_TURN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  async_sram_ctrl i_async_sram_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_we_i    (req_we),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .mem_addr_o  (mem_addr),
    .mem_cs_no   (mem_cs_n),
    .mem_oe_no   (mem_oe_n),
    .mem_we_no   (mem_we_n),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe),
    .mem_dq_i    (mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural memory and pin monitors, all at the falling edge
  logic [7:0]  mem [logic [18:0]];
  logic [7:0]  shadow [logic [18:0]];
  logic [7:0]  rd_word = '0;
  int          rd_age = 0, drv_hold = 0, we_run = 0, dq_run = 0;
  logic        prev_we = 1'b1, prev_cs = 1'b1, prev_dq_oe = 1'b0, addr_moved = 1'b0;
  logic [7:0]  prev_dq = '0;
  logic [18:0] prev_addr = '0;
  wire         mem_drv = !mem_cs_n && !mem_oe_n && mem_we_n;

  assign mem_dq_i = !mem_drv ? 8'hA5 : ((rd_age >= B_AA) ? rd_word : ~rd_word);

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_age = 0; drv_hold = 0; we_run = 0; dq_run = 0;
      prev_we = 1'b1; prev_cs = 1'b1; prev_dq_oe = 1'b0; addr_moved = 1'b0;
    end else begin
      // R6: both sides must never drive together, including the release window
      if (mem_dq_oe && (!prev_dq_oe || mem_drv || drv_hold > 0))
        chk(!(mem_drv || drv_hold > 0), "R6 bus contention", drv_hold, 0);
      if (mem_drv) drv_hold = B_TURN;
      else if (drv_hold > 0) drv_hold--;
      // R4: write strobe width
      if (!mem_we_n) we_run++;
      else begin
        if (we_run > 0) chk(we_run == B_WP, "R4 write strobe width", we_run, B_WP);
        we_run = 0;
      end
      // R5: setup before and hold at the strobe's rising edge
      if (mem_we_n && !prev_we) begin
        chk(dq_run >= B_DW, "R5 data setup cycles", dq_run, B_DW);
        chk(mem_dq_oe && mem_dq_o == prev_dq, "R5 data hold", {mem_dq_oe, mem_dq_o}, {1'b1, prev_dq});
      end
      if (!mem_dq_oe) dq_run = 0;
      else if (!prev_dq_oe || mem_dq_o != prev_dq) dq_run = 1;
      else dq_run++;
      // R8: address steady while selected
      if (!mem_cs_n && !prev_cs && mem_addr != prev_addr) addr_moved = 1'b1;
      if (mem_cs_n && !prev_cs) begin
        chk(!addr_moved, "R8 address moved under select", addr_moved, 0);
        addr_moved = 1'b0;
      end
      // model: read access time and write storage
      if (mem_drv) begin
        rd_age++;
        rd_word = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
      end else rd_age = 0;
      if (!mem_cs_n && !mem_we_n) mem[mem_addr] = mem_dq_o;
      prev_we = mem_we_n; prev_cs = mem_cs_n; prev_dq_oe = mem_dq_oe;
      prev_dq = mem_dq_o; prev_addr = mem_addr;
    end
  end

  task automatic idle_pins(input string tag);
    chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid, tag,
        {req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 6'b111100);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_cs_n && mem_oe_n && mem_we_n && mem_dq_oe && mem_addr == a && mem_dq_o == d,
        "R4 write setup pins", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0111);
    chk(!req_ready, "R7 busy after accept", req_ready, 0);
    n = 1;
    while (!req_ready) begin
      @(negedge clk);
      n++;
    end
    chk(n == WR_BUSY + 1, "R7 write busy length", n - 1, WR_BUSY);
    idle_pins("R1 idle after write");
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [18:0] a);
    int n;
    logic [7:0] exp;
    exp = shadow.exists(a) ? shadow[a] : 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == a,
        "R2 read pins", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
    n = 1;
    while (!rd_valid) begin
      @(negedge clk);
      n++;
    end
    chk(n == B_RD_LEN + 1, "R3 read latency", n, B_RD_LEN + 1);
    chk(rd_data == exp, "R9 read data", rd_data, exp);
    @(negedge clk);
    n++;
    chk(!rd_valid, "R3 valid pulse width", rd_valid, 0);
    while (!req_ready) begin
      @(negedge clk);
      n++;
    end
    chk(n == RD_BUSY + 1, "R7 read busy length", n - 1, RD_BUSY);
    idle_pins("R1 idle after read");
  endtask

  logic [18:0] addr_list [64];

  initial begin
    logic [18:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_pins("R1 pins in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R1 pins after reset");

    // address corners and walking ones
    do_write(19'h00000, 8'h11);
    do_write(19'h7FFFF, 8'hEE);
    for (int b = 0; b < 19; b++) do_write(19'(1) << b, 8'(b * 13 + 7));
    do_read(19'h00000);
    do_read(19'h7FFFF);
    for (int b = 0; b < 19; b++) do_read(19'(1) << b);

    // every byte value through one address
    for (int d = 0; d < 256; d++) begin
      do_write(19'h2AAAA, 8'(d));
      do_read(19'h2AAAA);
    end

    // overwrite then read latest
    do_write(19'h15555, 8'h3C);
    do_write(19'h15555, 8'hC3);
    do_read(19'h15555);

    // pseudo-random addresses, written first then read back
    lfsr = 19'h1ACE5;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[17:0], lfsr[18] ^ lfsr[17] ^ lfsr[16] ^ lfsr[13]};
      addr_list[i] = lfsr;
      do_write(lfsr, lfsr[7:0] ^ lfsr[18:11]);
    end
    for (int i = 63; i >= 0; i--) do_read(addr_list[i]);

    // back-to-back read then write then read, exercising turnaround
    for (int i = 0; i < 16; i++) begin
      do_read(addr_list[i]);
      do_write(addr_list[i], 8'(i * 31));
      do_read(addr_list[i]);
    end

    repeat (4) @(negedge clk);
    idle_pins("R1 idle at end");
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

endmodule